// File: doc/BRIEF.md
# Store Address Queue with Load Conflict Detection

This block lets an access pipeline issue a store as soon as its address is computed, without waiting for the value to be stored. The address is parked in an in-order queue. Later, when the execute side delivers the store value, that value is joined with the oldest parked address, and the pair leaves as one memory write request under a valid/ready handshake. If memory is not ready, nothing is lost: the address stays queued and the value source keeps its word presented.

Because stores now complete late, a load could overtake an older store to the same location. Every load address presented to the block is compared at once against all parked store addresses. A store being accepted in that same cycle is included. On any match a combinational hold is raised in the load's issue cycle. The load, and every load behind it in issue order, waits until the conflicting entry has drained. A separate empty indication tells the pipeline when a non-store consumer of the value stream, such as address arithmetic, may proceed.

Top module: `store_addr_queue`

## Requirements
- R1: After reset the queue is empty: `drained` is 1, and `wr_valid`, `st_stall`, `sd_ready` and `ld_hold` are 0.
- R2: A store address offered while fewer than DEPTH entries are held is accepted at the next clock edge. While DEPTH entries are held, `st_stall` equals `st_addr_valid`, and the refused address is never stored. Acceptance depends only on the occupancy at the start of the cycle.
- R3: Write requests carry the accepted store addresses in strict acceptance order.
- R4: `wr_valid` is 1 exactly when `sd_valid` is 1 and at least one entry is held. `wr_addr` is the oldest entry and `wr_data` equals `sd_data`. `sd_ready` is 1 exactly when an entry is held and `wr_ready` is 1. An entry leaves when `wr_valid` and `wr_ready` are both 1.
- R5: While `wr_ready` is 0 no entry leaves, and `wr_addr` keeps its value into the next cycle.
- R6: `ld_hold` is a combinational function of the current inputs and state. It is 1 when `ld_valid` is 1 and `ld_addr` equals any held entry.
- R7: An entry still takes part in the comparison during the cycle in which its write is accepted, and takes no part from the next cycle on.
- R8: A store address being accepted in the same cycle as a load is compared with that load as an older store.
- R9: `drained` is 1 exactly when no entry is held.
- R10: `ld_hold` is 0 whenever `ld_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_addr_valid | input | 1 | Store address offered |
| st_addr | input | ADDR_W | Store address |
| st_stall | output | 1 | Store address refused, queue full |
| sd_valid | input | 1 | Store value offered by the execute side |
| sd_data | input | DATA_W | Store value |
| sd_ready | output | 1 | Store value consumed this cycle if valid |
| wr_valid | output | 1 | Memory write request |
| wr_addr | output | ADDR_W | Write address (oldest entry) |
| wr_data | output | DATA_W | Write value |
| wr_ready | input | 1 | Memory accepts the write |
| ld_valid | input | 1 | Load address presented for checking |
| ld_addr | input | ADDR_W | Load address |
| ld_hold | output | 1 | Load conflicts with a pending store |
| drained | output | 1 | No store address held |

## Verification
Two events can share one cycle. In the first, a new store address enters while the oldest one leaves. In the second, a load is checked while its conflicting entry is either retiring or only arriving. The bench forces both directly: it fills a four-entry queue, retires an entry whose address a load is presenting at the same moment, and accepts a store whose address matches the load in that cycle. A long run of pseudo-random cycles over a 4-bit address space then makes both coincidences frequent. Each cycle's outputs are judged against an arithmetic shadow queue that is updated at the clock edge in the order retire, then append.

// File: rtl/store_addr_queue.sv
module store_addr_queue #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_addr_valid,
  input  logic [ADDR_W-1:0] st_addr,
  output logic              st_stall,
  input  logic              sd_valid,
  input  logic [DATA_W-1:0] sd_data,
  output logic              sd_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ready,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_hold,
  output logic              drained
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] slot [DEPTH];
  logic [DEPTH-1:0]  live, live_n, hit;
  logic [PW-1:0]     head, tail;
  logic [CW-1:0]     count;
  logic              full, enq, pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CW'(DEPTH));
  assign drained  = (count == '0);
  assign enq      = st_addr_valid & ~full;
  assign st_stall = st_addr_valid & full;
  assign wr_valid = sd_valid & ~drained;
  assign sd_ready = ~drained & wr_ready;
  assign pop      = wr_valid & wr_ready;
  assign wr_addr  = slot[head];
  assign wr_data  = sd_data;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = live[i] & (slot[i] == ld_addr);
  end

  assign ld_hold = ld_valid & ((|hit) | (enq & (st_addr == ld_addr)));

  always_comb begin
    live_n = live;
    if (pop) live_n[head] = 1'b0;
    if (enq) live_n[tail] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      live  <= '0;
    end else begin
      live <= live_n;
      if (pop) head <= step(head);
      if (enq) tail <= step(tail);
      if (enq && !pop)      count <= count + 1'b1;
      else if (pop && !enq) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (enq) slot[tail] <= st_addr;
  end
endmodule

module store_addr_queue_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_addr_valid,
  input logic              st_stall,
  input logic              sd_valid,
  input logic [DATA_W-1:0] sd_data,
  input logic              sd_ready,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_ready,
  input logic              ld_valid,
  input logic              ld_hold,
  input logic              drained
);
  p_stall_means_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_stall |=> !drained);
  p_no_write_when_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> (!wr_valid && !sd_ready));
  p_data_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (sd_valid && wr_data == sd_data));
  p_retain_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_addr == $past(wr_addr)));
  p_hold_needs_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hold |-> ld_valid);
  p_empty_no_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drained && !st_addr_valid) |-> !ld_hold);
endmodule

bind store_addr_queue store_addr_queue_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/store_addr_queue_tb.sv
`timescale 1ns/1ps
module store_addr_queue_tb;
  localparam int D = 4, AW = 4, DW = 8;

  logic clk = 0, rst_n = 0;
  logic st_addr_valid = 0, sd_valid = 0, wr_ready = 0, ld_valid = 0;
  logic [AW-1:0] st_addr = 0, ld_addr = 0;
  logic [DW-1:0] sd_data = 0;
  logic st_stall, sd_ready, wr_valid, ld_hold, drained;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int tests = 0, fails = 0;
  logic [AW-1:0] mq [D];
  int cnt = 0;

  always #5 clk = ~clk;

  store_addr_queue #(.DEPTH(D), .ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one cycle: drive after negedge, check settled outputs, update model at posedge
  task automatic cyc(input logic sv, input logic [AW-1:0] sa, input logic dv,
                     input logic [DW-1:0] dd, input logic lv, input logic [AW-1:0] la,
                     input logic rdy);
    logic enq, pop, hold;
    @(negedge clk);
    st_addr_valid = sv; st_addr = sa; sd_valid = dv; sd_data = dd;
    ld_valid = lv; ld_addr = la; wr_ready = rdy;
    #1;
    enq = sv && cnt < D;
    pop = dv && cnt > 0 && rdy;
    hold = 0;
    for (int i = 0; i < cnt; i++) if (mq[i] == la) hold = 1;
    if (enq && sa == la) hold = 1;
    hold = hold && lv;
    chk("R2 st_stall", st_stall, sv && cnt == D);
    chk("R4 wr_valid", wr_valid, dv && cnt > 0);
    chk("R4 sd_ready", sd_ready, cnt > 0 && rdy);
    if (dv && cnt > 0) begin
      chk("R3 wr_addr order", wr_addr, mq[0]);
      chk("R4 wr_data", wr_data, dd);
    end
    chk("R6 R7 R8 R10 ld_hold", ld_hold, hold);
    chk("R9 drained", drained, cnt == 0);
    @(posedge clk);
    if (pop) begin
      for (int i = 0; i < D - 1; i++) mq[i] = mq[i+1];
      cnt--;
    end
    if (enq) begin mq[cnt] = sa; cnt++; end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    #1;
    chk("R1 drained", drained, 1);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 st_stall", st_stall, 0);
    chk("R1 sd_ready", sd_ready, 0);
    chk("R1 ld_hold", ld_hold, 0);
    repeat (2) @(posedge clk);
    rst_n = 1;
    // R2: fill with 3,7,3,12 then overflow attempt with 9 (refused)
    cyc(1, 3, 0, 0, 0, 0, 0);
    cyc(1, 7, 0, 0, 0, 0, 0);
    cyc(1, 3, 0, 0, 0, 0, 0);
    cyc(1, 12, 0, 0, 0, 0, 0);
    cyc(1, 9, 0, 0, 1, 9, 1);   // R2 full: stall, 9 not visible to load
    // R6: sweep every load address against a full queue
    for (int a = 0; a < 16; a++) cyc(0, 0, 0, 0, 1, a[AW-1:0], 0);
    // R5: memory not ready, address retained
    cyc(0, 0, 1, 8'h11, 0, 0, 0);
    cyc(0, 0, 1, 8'h11, 0, 0, 0);
    // R7: retire 3 while a load of 3 looks (duplicate still queued)
    cyc(0, 0, 1, 8'h11, 1, 3, 1);
    // R7: retire 7 while a load of 7 looks: still held this cycle
    cyc(0, 0, 1, 8'h22, 1, 7, 1);
    cyc(0, 0, 0, 0, 1, 7, 0);   // R7: next cycle free
    // R8: enqueue 5 with a load of 5 in the same cycle; also pop together
    cyc(1, 5, 1, 8'h33, 1, 5, 1);
    cyc(1, 6, 1, 8'h44, 1, 12, 1);
    // drain, then R9
    for (int k = 0; k < 4; k++) cyc(0, 0, 1, 8'h55, 0, 0, 1);
    // pseudo-random near-exhaustive phase
    lf = 16'hACE1;
    for (int n = 0; n < 6000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0], lf[4:1], lf[5] | lf[6], lf[15:8], lf[7], lf[11:8], lf[12] | lf[13]);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule